// File: doc/BRIEF.md
# Framed Byte-Stream Packet Parser

This block sits behind a serial byte receiver and turns a raw byte stream into whole packets. Each received byte arrives with a one-cycle valid strobe. The parser keeps the most recent bytes in a sliding window to find a start marker at any offset. It then takes one length byte and stores exactly that many payload bytes. Four end-marker bytes must follow, and the packet is released only if they all match.

An accepted packet raises a one-cycle packet-valid pulse and latches its length. A busy flag then stays up while a consumer reads the payload through an asynchronous read port. The consumer ends the read-out with a one-cycle done pulse. Frames with a bad end marker vanish without a trace. Frames that complete while the previous packet is still being read are dropped and counted in a saturating counter.

Top module: `frame_parser`

## Requirements
- R1: After reset `pkt_valid` and `busy` are 0 and `drop_cnt` is 0.
- R2: A frame starts after four consecutive accepted bytes of value 0x55. The match is found at any byte offset in the stream, so leading 0x55 bytes that are followed by a different byte do not prevent a later match.
- R3: The accepted byte right after the start marker is the payload length N (0 to 255). Exactly N following accepted bytes are stored at read addresses 0 to N-1, and `rd_data` shows the byte at `rd_addr` in the same cycle.
- R4: When the four accepted bytes after the payload are all 0xAA, `pkt_valid` is high for exactly one cycle, starting in the cycle after the last of them is accepted. In the same cycle `pkt_len` takes the value N, and it holds that value until the next commit.
- R5: If any of the four end-marker bytes differs from 0xAA, no pulse is raised and `busy`, `pkt_len` and `drop_cnt` keep their values. After the fourth byte the parser searches for a start marker again.
- R6: A length byte of 0 goes straight to end-marker checking, and a good end marker then commits a packet with `pkt_len` = 0.
- R7: The start-marker history is emptied each time the parser returns to searching. Bytes seen before a finished frame therefore never combine with bytes after it, and a single 0x55 after a frame cannot start a new one.
- R8: A commit sets `busy`, and a one-cycle `rd_done` pulse clears it. A frame whose length byte arrives while `busy` is high never writes the payload store. If it ends with a good end marker, it raises no pulse, leaves `pkt_len` unchanged and increments `drop_cnt`.
- R9: Bytes presented while `in_valid` is low have no effect on the parser.
- R10: `drop_cnt` counts up by one per dropped frame and saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Byte strobe from the receiver |
| in_byte | input | 8 | Received byte |
| rd_done | input | 1 | Consumer has finished reading the held packet |
| rd_addr | input | 8 | Payload read address |
| pkt_valid | output | 1 | One-cycle pulse on packet commit |
| pkt_len | output | 8 | Length of the last committed packet |
| busy | output | 1 | Committed packet is being read out |
| rd_data | output | 8 | Payload byte at `rd_addr` |
| drop_cnt | output | 8 | Saturating count of frames dropped while busy |

## Verification
The bench puts 0x55 runs in front of a real start marker. A parser that only matches on aligned groups of four would miss the frame. A single 0x55 after a finished frame must not start a new one, because a window that is not emptied would match on it. Each end-marker position is corrupted in turn and zero-length frames are sent, which catches a parser that checks only some end bytes or that underflows the length. Frames sent while a packet is held must leave the held payload and `pkt_len` untouched, and the counter is pushed past 255 to catch wrap-around.

// File: rtl/frame_parser_pkg.sv
// Shared types for the framed byte-stream parser.
// Assumes: the state order below is the parse order of one frame.
package frame_parser_pkg;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,   // sliding search for the start marker
        ST_LEN  = 2'd1,   // next byte is the payload length
        ST_BODY = 2'd2,   // capturing payload bytes
        ST_TAIL = 2'd3    // checking the end marker
    } fp_state_e;

endpackage

// File: rtl/fp_mark_window.sv
// Sliding window that compares the last MARK_N bytes with a fixed value.
// It keeps MARK_N-1 past bytes. `hit` is combinational and includes the byte
// presented now, so a match is seen in the cycle its last byte is accepted.
// Assumes: MARK_N >= 2. `clear` has priority over `shift`.
module fp_mark_window #(
    parameter int          BYTE_W = 8,
    parameter int          MARK_N = 4,
    parameter logic [7:0]  MARK   = 8'h55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift,
    input  logic              clear,
    input  logic [BYTE_W-1:0] din,
    output logic              hit
);
    localparam int HIST = MARK_N - 1;
    localparam logic [BYTE_W-1:0] MARK_V = BYTE_W'(MARK);

    logic [HIST-1:0][BYTE_W-1:0] hist_q;
    logic [HIST-1:0]             lane_eq;

    // History register: cleared on request, otherwise shifts in accepted bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (clear) begin
            hist_q <= '0;
        end else if (shift) begin
            hist_q[0] <= din;
            for (int i = 1; i < HIST; i++) begin
                hist_q[i] <= hist_q[i-1];
            end
        end
    end

    // One comparator per stored lane.
    for (genvar g = 0; g < HIST; g++) begin : g_lane
        assign lane_eq[g] = (hist_q[g] == MARK_V);
    end

    // Match needs every stored lane plus the current byte.
    assign hit = (din == MARK_V) && (&lane_eq);

endmodule

// File: rtl/fp_payload_store.sv
// Payload buffer: one write port and one combinational read port.
// Assumes: DEPTH covers every address the length field can name.
module fp_payload_store #(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [BYTE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] mem_q [DEPTH];

    // Write port: the storage needs no reset, only written bytes are read.
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // Read port: asynchronous lookup.
    assign rdata = mem_q[raddr];

endmodule

// File: rtl/fp_frame_ctrl.sv
// Frame sequencer: start search, length capture, payload indexing, end-marker
// verdict, commit/busy handshake and the drop counter.
// Assumes: the length field is as wide as a byte, and the window hits come
// from fp_mark_window instances driven by the shift/clear outputs here.
module fp_frame_ctrl
    import frame_parser_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int MARK_N = 4,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              hdr_hit,
    input  logic              tail_hit,
    input  logic              rd_done,
    output logic              hdr_shift,
    output logic              hdr_clear,
    output logic              tail_shift,
    output logic              tail_clear,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_addr,
    output logic              pkt_valid,
    output logic [BYTE_W-1:0] pkt_len,
    output logic              busy,
    output logic [CNT_W-1:0]  drop_cnt
);
    localparam logic [BYTE_W-1:0] TAIL_LAST = BYTE_W'(MARK_N - 1);

    fp_state_e         st_q, st_d;
    logic [BYTE_W-1:0] idx_q, len_q, plen_q;
    logic              blocked_q, busy_q, pulse_q;
    logic [CNT_W-1:0]  drop_q;
    logic              body_last, tail_last, tail_done, commit, drop;

    // Window and store control derived from the current state.
    always_comb begin
        hdr_shift  = in_valid && (st_q == ST_HUNT);
        hdr_clear  = (st_q != ST_HUNT) || (hdr_shift && hdr_hit);
        tail_shift = in_valid && (st_q == ST_TAIL);
        tail_clear = (st_q != ST_TAIL);
        wr_en      = in_valid && (st_q == ST_BODY) && !blocked_q;
        wr_addr    = idx_q;
    end

    // Position flags and end-of-frame verdict.
    always_comb begin
        body_last = (idx_q == len_q - 1'b1);
        tail_last = (idx_q == TAIL_LAST);
        tail_done = tail_shift && tail_last;
        commit    = tail_done && tail_hit && !blocked_q && !busy_q;
        drop      = tail_done && tail_hit && (blocked_q || busy_q);
    end

    // Next-state selection, advanced only by accepted bytes.
    always_comb begin
        st_d = st_q;
        if (in_valid) begin
            unique case (st_q)
                ST_HUNT: if (hdr_hit)                 st_d = ST_LEN;
                ST_LEN:  st_d = (in_byte == '0) ? ST_TAIL : ST_BODY;
                ST_BODY: if (body_last)               st_d = ST_TAIL;
                ST_TAIL: if (tail_last)               st_d = ST_HUNT;
                default:                              st_d = ST_HUNT;
            endcase
        end
    end

    // State, index, length and block flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_HUNT;
            idx_q     <= '0;
            len_q     <= '0;
            blocked_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (in_valid) begin
                unique case (st_q)
                    ST_HUNT: idx_q <= '0;
                    ST_LEN: begin
                        len_q     <= in_byte;
                        blocked_q <= busy_q;
                        idx_q     <= '0;
                    end
                    ST_BODY: idx_q <= body_last ? '0 : idx_q + 1'b1;
                    ST_TAIL: idx_q <= tail_last ? '0 : idx_q + 1'b1;
                    default: idx_q <= '0;
                endcase
            end
        end
    end

    // Commit pulse, held length and the busy handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            plen_q  <= '0;
            busy_q  <= 1'b0;
        end else begin
            pulse_q <= commit;
            if (commit) begin
                plen_q <= len_q;
                busy_q <= 1'b1;
            end else if (rd_done) begin
                busy_q <= 1'b0;
            end
        end
    end

    // Saturating count of good frames lost to a held packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drop_q <= '0;
        end else if (drop && (drop_q != '1)) begin
            drop_q <= drop_q + 1'b1;
        end
    end

    assign pkt_valid = pulse_q;
    assign pkt_len   = plen_q;
    assign busy      = busy_q;
    assign drop_cnt  = drop_q;

endmodule

// File: rtl/frame_parser.sv
// Framed byte-stream packet parser top level.
// Puts together the start-marker window, the end-marker window, the frame
// sequencer and the payload store.
// Assumes: bytes arrive at most one per cycle under in_valid.
module frame_parser #(
    parameter int         BYTE_W   = 8,
    parameter int         MARK_N   = 4,
    parameter logic [7:0] HDR_BYTE = 8'h55,
    parameter logic [7:0] TRL_BYTE = 8'hAA,
    parameter int         CNT_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              rd_done,
    input  logic [BYTE_W-1:0] rd_addr,
    output logic              pkt_valid,
    output logic [BYTE_W-1:0] pkt_len,
    output logic              busy,
    output logic [BYTE_W-1:0] rd_data,
    output logic [CNT_W-1:0]  drop_cnt
);
    logic              hdr_shift, hdr_clear, hdr_hit;
    logic              tail_shift, tail_clear, tail_hit;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_addr;

    fp_mark_window #(.BYTE_W(BYTE_W), .MARK_N(MARK_N), .MARK(HDR_BYTE)) u_hdr_win (
        .clk(clk), .rst_n(rst_n), .shift(hdr_shift), .clear(hdr_clear),
        .din(in_byte), .hit(hdr_hit)
    );

    fp_mark_window #(.BYTE_W(BYTE_W), .MARK_N(MARK_N), .MARK(TRL_BYTE)) u_tail_win (
        .clk(clk), .rst_n(rst_n), .shift(tail_shift), .clear(tail_clear),
        .din(in_byte), .hit(tail_hit)
    );

    fp_frame_ctrl #(.BYTE_W(BYTE_W), .MARK_N(MARK_N), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .hdr_hit(hdr_hit), .tail_hit(tail_hit), .rd_done(rd_done),
        .hdr_shift(hdr_shift), .hdr_clear(hdr_clear),
        .tail_shift(tail_shift), .tail_clear(tail_clear),
        .wr_en(wr_en), .wr_addr(wr_addr),
        .pkt_valid(pkt_valid), .pkt_len(pkt_len), .busy(busy), .drop_cnt(drop_cnt)
    );

    fp_payload_store #(.BYTE_W(BYTE_W), .ADDR_W(BYTE_W)) u_store (
        .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(in_byte),
        .raddr(rd_addr), .rdata(rd_data)
    );

endmodule

// File: rtl/frame_parser_chk.sv
// Port-level property checker for frame_parser, attached by bind below.
module frame_parser_chk #(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              rd_done,
    input logic              pkt_valid,
    input logic [BYTE_W-1:0] pkt_len,
    input logic              busy,
    input logic [CNT_W-1:0]  drop_cnt
);
    // R4: the commit pulse lasts one cycle
    p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |=> !pkt_valid);

    // R4: the held length changes only together with a commit
    p_len_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_valid |-> $stable(pkt_len));

    // R8: a commit leaves busy set
    p_commit_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> busy);

    // R8: no commit while a packet was held
    p_no_commit_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> !$past(busy));

    // R8: the done pulse releases a held packet
    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_done) |=> !busy);

    // R8: a drop never coincides with a commit
    p_drop_not_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_cnt != $past(drop_cnt)) |-> !pkt_valid);

    // R10: the counter moves by one step at most
    p_drop_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_cnt != $past(drop_cnt)) |-> (drop_cnt == $past(drop_cnt) + 1'b1));

    // R10: the counter stays at its all-ones value
    p_drop_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_cnt == '1) |=> (drop_cnt == '1));

    // R9: without a strobe there is nothing to commit
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !pkt_valid);

endmodule

bind frame_parser frame_parser_chk #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .rd_done(rd_done),
    .pkt_valid(pkt_valid), .pkt_len(pkt_len), .busy(busy), .drop_cnt(drop_cnt)
);

// File: tb/frame_parser_tb_top.sv
`timescale 1ns/1ps
module frame_parser_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       rd_done = 1'b0;
    logic [7:0] rd_addr = 8'h00;
    logic       pkt_valid, busy;
    logic [7:0] pkt_len, rd_data, drop_cnt;

    int n_vec = 0, n_bad = 0, pulses = 0;
    int exp_pulses = 0, exp_drop = 0, exp_len = 0;
    logic [7:0] pay  [256];
    logic [7:0] held [256];

    always #2 clk = ~clk;

    frame_parser dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .rd_done(rd_done), .rd_addr(rd_addr), .pkt_valid(pkt_valid),
        .pkt_len(pkt_len), .busy(busy), .rd_data(rd_data), .drop_cnt(drop_cnt)
    );

    always @(negedge clk) if (rst_n && pkt_valid) pulses++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk); in_valid = 1'b1; in_byte = b;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(negedge clk); in_valid = 1'b0; end
    endtask

    task automatic fill_pay(input int len);
        for (int i = 0; i < len; i++) pay[i] = 8'($urandom);
    endtask

    task automatic garbage(input int n);
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            b = 8'($urandom);
            if (b == 8'h55) b = 8'h00;
            put(b);
        end
    endtask

    // bad_pos < 0 gives a good end marker
    task automatic send_frame(input int len, input int bad_pos, input logic [7:0] bad_val);
        repeat (4) put(8'h55);
        put(8'(len));
        for (int i = 0; i < len; i++) put(pay[i]);
        for (int i = 0; i < 4; i++) put((i == bad_pos) ? bad_val : 8'hAA);
        idle(2);
    endtask

    task automatic readback(input string req, input int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk); rd_addr = 8'(i);
            #1 chk(rd_data == held[i], req, int'(rd_data), int'(held[i]));
        end
    endtask

    task automatic release_rd(input string req);
        @(negedge clk); rd_done = 1'b1;
        @(negedge clk); rd_done = 1'b0;
        #1 chk(busy == 1'b0, req, int'(busy), 0);
    endtask

    task automatic expect_commit(input string req, input int len);
        exp_pulses++;
        exp_len = len;
        for (int i = 0; i < len; i++) held[i] = pay[i];
        chk(pulses == exp_pulses, req, pulses, exp_pulses);
        chk(int'(pkt_len) == len, req, int'(pkt_len), len);
        chk(busy == 1'b1, req, int'(busy), 1);
    endtask

    task automatic expect_none(input string req);
        chk(pulses == exp_pulses, req, pulses, exp_pulses);
        chk(int'(pkt_len) == exp_len, req, int'(pkt_len), exp_len);
        chk(int'(drop_cnt) == exp_drop, req, int'(drop_cnt), exp_drop);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(pkt_valid == 1'b0, "R1 pkt_valid", int'(pkt_valid), 0);
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(drop_cnt == 8'd0, "R1 drop_cnt", int'(drop_cnt), 0);

        // R2: unaligned start after a broken 0x55 run
        put(8'h55); put(8'h55); put(8'h55); put(8'h12);
        fill_pay(5); send_frame(5, -1, 8'h00);
        expect_commit("R2 offset start", 5);
        readback("R3 payload", 5);
        release_rd("R8 release");

        // R6: empty payload
        send_frame(0, -1, 8'h00);
        expect_commit("R6 zero length", 0);
        release_rd("R8 release zero");

        // R5: each end-marker position corrupted
        for (int p = 0; p < 4; p++) begin
            fill_pay(3);
            send_frame(3, p, 8'hA5);
            expect_none("R5 bad trailer");
            chk(busy == 1'b0, "R5 busy stays low", int'(busy), 0);
        end

        // R7: one 0x55 after a finished frame must not start another
        fill_pay(2); send_frame(2, -1, 8'h00);
        expect_commit("R4 commit", 2);
        release_rd("R8 release");
        put(8'h55); put(8'h03); put(8'h01); put(8'h02); put(8'h03);
        repeat (4) put(8'hAA);
        idle(2);
        expect_none("R7 history cleared");

        // R9: 0x55 shown without strobe is ignored
        garbage(2);
        @(negedge clk); in_valid = 1'b0; in_byte = 8'h55;
        repeat (10) @(negedge clk);
        put(8'h55); put(8'h02); put(8'h07); put(8'h08);
        repeat (4) put(8'hAA);
        idle(2);
        expect_none("R9 strobe low ignored");

        // R3/R4: full 255-byte payload
        garbage(3);
        fill_pay(255); send_frame(255, -1, 8'h00);
        expect_commit("R4 max length", 255);
        readback("R3 max payload", 255);
        release_rd("R8 release");

        // R8: frame completing while busy is dropped and counted
        fill_pay(4); send_frame(4, -1, 8'h00);
        expect_commit("R8 first", 4);
        fill_pay(6); send_frame(6, -1, 8'h00);
        exp_drop++;
        expect_none("R8 dropped while busy");
        readback("R8 held payload intact", 4);
        release_rd("R8 release");

        // random mixed traffic
        for (int it = 0; it < 60; it++) begin
            int len, bad;
            garbage(int'($urandom % 6));
            idle(int'($urandom % 3));
            len = ($urandom % 8 == 0) ? 255 : int'($urandom % 24);
            bad = ($urandom % 4 == 0) ? int'($urandom % 4) : -1;
            fill_pay(len);
            send_frame(len, bad, 8'(8'h01 + ($urandom % 8'h80)));
            if (bad < 0) begin
                expect_commit("R4 random commit", len);
                readback("R3 random payload", len);
                release_rd("R8 random release");
            end else begin
                expect_none("R5 random bad trailer");
            end
        end

        // R10: saturation of the drop counter
        fill_pay(1); send_frame(1, -1, 8'h00);
        expect_commit("R10 holder", 1);
        for (int k = 0; k < 260; k++) begin
            send_frame(0, -1, 8'h00);
            if (exp_drop < 255) exp_drop++;
        end
        chk(int'(drop_cnt) == 255, "R10 saturation", int'(drop_cnt), 255);
        expect_none("R10 nothing committed");
        release_rd("R8 final release");

        summary();
        $finish;
    end
endmodule